// File: doc/BRIEF.md
# Basic Update-Event Timer

A 16-bit up-counter driven through a programmable prescaler. While counting is enabled, the prescaler steps once per clock. Each time it wraps from its limit back to zero, the main counter advances by one. When the counter sits at the reload value, the next advance returns it to zero and raises an update event.

Software can also force an update. It does this by writing a request bit, which zeroes both the counter and the prescaler. Two gating inputs decide whether an event marks the pending flag:

- A block input suppresses flag setting for every update.
- A quiet input suppresses flag setting for software-forced updates only.

The flag lives in a status word and is cleared by writing zero to it. A copy of the flag also appears in the top bit of the counter read word. An interrupt line shows the flag when the interrupt enable input allows it.

The counter enable, block, quiet, interrupt enable, prescaler limit and reload value are plain input ports. The register port is a one-cycle write strobe with address and data, plus a combinational read of the addressed word.

Top module: `upd_timer`

## Requirements
- R1: After reset the counter, prescaler and pending flag are zero, so every readable word returns 0.
- R2: With `run_i` high, the counter advances once every `psc_lim_i`+1 clocks. With `run_i` low, the counter and prescaler hold.
- R3: An advance from a counter equal to `reload_i` returns the counter to 0 and raises an update event. If `upd_block_i` is 0, the flag is 1 in the following cycle.
- R4: With `upd_block_i` high, no event of either kind sets the flag, but the counter still wraps to 0.
- R5: Writing 1 to bit 0 at offset 0x14 leaves the counter and the prescaler at 0 in the next cycle. The prescaler limit is not altered.
- R6: A forced update sets the flag only when both `upd_block_i` and `sw_quiet_i` are 0.
- R7: Writing 0 to bit 0 at offset 0x10 clears the flag, and writing 1 there has no effect. If a set and a clear fall in the same cycle, the flag ends up 1.
- R8: A write at offset 0x24 loads bits 15:0 into the counter. In the same cycle it overrides any advance, and that advance raises no event.
- R9: Reads are decoded as follows, and every other bit and address reads 0:
  - offset 0x10 returns the flag in bit 0;
  - offset 0x14 always returns 0;
  - offset 0x24 returns the counter in bits 15:0 and the flag in bit 31.
- R10: `irq_o` equals the flag ANDed with `irq_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter enable |
| upd_block_i | input | 1 | Suppress flag setting on all updates |
| sw_quiet_i | input | 1 | Suppress flag setting on forced updates |
| irq_en_i | input | 1 | Interrupt enable |
| psc_lim_i | input | 16 | Prescaler limit (divide by value+1) |
| reload_i | input | 16 | Counter reload (top) value |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that only one register is written per cycle. They also assume that `upd_block_i` and `sw_quiet_i` are sampled in the same cycle as the event they gate. Their clear and set checks therefore reason about a single write at a time. The stimulus drives at most one write per cycle, at an offset drawn from the three mapped words plus an unmapped one. It keeps the prescaler limit and reload value small (0 to 3 and 0 to 7), so that wraps, forced updates and same-cycle set/clear collisions all occur often.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;
    localparam logic [7:0] OFS_STAT = 8'h10;
    localparam logic [7:0] OFS_EVT  = 8'h14;
    localparam logic [7:0] OFS_CNT  = 8'h24;
    localparam int unsigned MIRROR_BIT = 31;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         tick_o,
    output logic [W-1:0] val_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ps_t;

    ps_t st_d, st_q;
    logic at_lim;

    always_comb begin
        st_d   = st_q;
        at_lim = (st_q.cnt == limit);
        tick_o = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (at_lim) begin
                st_d.cnt = '0;
                tick_o   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.cnt;
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reinit,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] top_val,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ct_t;

    ct_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (reinit) begin
            st_d.cnt = '0;
        end else if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (st_q.cnt == top_val) begin
                st_d.cnt = '0;
                wrap_o   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_evt,
    input  logic sw_evt,
    input  logic block,
    input  logic quiet,
    input  logic clr_req,
    output logic flag_o
);
    typedef struct packed {
        logic pend;
    } fl_t;

    fl_t  st_d, st_q;
    logic set_hw, set_sw;

    always_comb begin
        st_d   = st_q;
        set_hw = hw_evt && !block;
        set_sw = sw_evt && !block && !quiet;
        if (set_hw || set_sw) st_d.pend = 1'b1;
        else if (clr_req)     st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.pend;
endmodule

// File: rtl/upd_timer.sv
module upd_timer
    import upd_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              upd_block_i,
    input  logic              sw_quiet_i,
    input  logic              irq_en_i,
    input  logic [CNT_W-1:0]  psc_lim_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam int unsigned HI_W = DATA_W - CNT_W;

    logic             ug_req, cnt_wr, stat_clr;
    logic             ps_tick, ovf_evt, flag_q;
    logic [CNT_W-1:0] psc_val, cnt_val;
    logic [HI_W-1:0]  unused_hi;

    assign ug_req    = wr_i && (addr_i == ADDR_W'(OFS_EVT)) && wdata_i[0];
    assign cnt_wr    = wr_i && (addr_i == ADDR_W'(OFS_CNT));
    assign stat_clr  = wr_i && (addr_i == ADDR_W'(OFS_STAT)) && !wdata_i[0];
    assign unused_hi = wdata_i[DATA_W-1:CNT_W];

    tmr_prescale #(.W(CNT_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run_i), .clear(ug_req),
        .limit(psc_lim_i), .tick_o(ps_tick), .val_o(psc_val)
    );

    tmr_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(ps_tick), .reinit(ug_req),
        .load(cnt_wr), .load_val(wdata_i[CNT_W-1:0]), .top_val(reload_i),
        .cnt_o(cnt_val), .wrap_o(ovf_evt)
    );

    tmr_flag u_flag (
        .clk(clk), .rst_n(rst_n), .hw_evt(ovf_evt), .sw_evt(ug_req),
        .block(upd_block_i), .quiet(sw_quiet_i), .clr_req(stat_clr),
        .flag_o(flag_q)
    );

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_STAT)) begin
            rdata_o[0] = flag_q;
        end else if (addr_i == ADDR_W'(OFS_CNT)) begin
            rdata_o[CNT_W-1:0]  = cnt_val;
            rdata_o[MIRROR_BIT] = flag_q;
        end
    end

    assign irq_o = flag_q & irq_en_i;
endmodule

// File: rtl/upd_timer_chk.sv
module upd_timer_chk
    import upd_timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              upd_block_i,
    input logic              sw_quiet_i,
    input logic              flag_q,
    input logic              ovf_evt,
    input logic [CNT_W-1:0]  cnt_val,
    input logic [CNT_W-1:0]  psc_val
);
    logic ug_w, clr_w;
    assign ug_w  = wr_i && (addr_i == ADDR_W'(OFS_EVT)) && wdata_i[0];
    assign clr_w = wr_i && (addr_i == ADDR_W'(OFS_STAT)) && !wdata_i[0];

    p_hw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !upd_block_i) |=> flag_q);

    p_block_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_block_i && !flag_q) |=> !flag_q);

    p_ug_reinit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ug_w |=> (cnt_val == '0 && psc_val == '0));

    p_quiet_sw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ug_w && sw_quiet_i && !flag_q && !ovf_evt) |=> !flag_q);

    p_sw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !ovf_evt) |=> !flag_q);
endmodule

bind upd_timer upd_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .upd_block_i(upd_block_i), .sw_quiet_i(sw_quiet_i), .flag_q(flag_q),
    .ovf_evt(ovf_evt), .cnt_val(cnt_val), .psc_val(psc_val)
);

// File: tb/upd_timer_bench.sv
module upd_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0, upd_block_i = 1'b0, sw_quiet_i = 1'b0, irq_en_i = 1'b0;
    logic [15:0] psc_lim_i = '0, reload_i = '0;
    logic        wr_i = 1'b0;
    logic [7:0]  addr_i = 8'h00;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int unsigned n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    logic [15:0] m_cnt = '0, m_psc = '0;
    logic        m_flag = 1'b0;

    upd_timer u_upd_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .upd_block_i(upd_block_i),
        .sw_quiet_i(sw_quiet_i), .irq_en_i(irq_en_i), .psc_lim_i(psc_lim_i),
        .reload_i(reload_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h10) r[0] = m_flag;
        else if (a == 8'h24) begin r[15:0] = m_cnt; r[31] = m_flag; end
        return r;
    endfunction

    function automatic string tag_for(logic [7:0] a);
        if (a == 8'h10) return "R7";
        if (a == 8'h24) return "R2";
        return "R9";
    endfunction

    task automatic chk32(logic [31:0] act, logic [31:0] exp, string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic ug, cw, clr, tick, ovf, set;
        ug   = wr_i && addr_i == 8'h14 && wdata_i[0];
        cw   = wr_i && addr_i == 8'h24;
        clr  = wr_i && addr_i == 8'h10 && !wdata_i[0];
        tick = !ug && run_i && (m_psc == psc_lim_i);
        ovf  = tick && !cw && (m_cnt == reload_i);
        set  = (ovf && !upd_block_i) || (ug && !upd_block_i && !sw_quiet_i);
        if (ug) m_psc = '0;
        else if (run_i) m_psc = (m_psc == psc_lim_i) ? 16'd0 : m_psc + 16'd1;
        if (ug) m_cnt = '0;
        else if (cw) m_cnt = wdata_i[15:0];
        else if (tick) m_cnt = (m_cnt == reload_i) ? 16'd0 : m_cnt + 16'd1;
        if (set) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
    endtask

    // inputs are set right after a negedge; check, advance model, wait a cycle
    task automatic cyc(string tag);
        #1;
        chk32(rdata_o, exp_rd(addr_i), (tag == "") ? tag_for(addr_i) : tag);
        chk32({31'b0, irq_o}, {31'b0, m_flag & irq_en_i}, "R10");
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_i = 1'b0; wdata_i = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on each mapped word
        addr_i = 8'h24; cyc("R1");
        addr_i = 8'h10; cyc("R1");
        addr_i = 8'h14; cyc("R1");

        // R2: divide by 3, observe counter climbing
        psc_lim_i = 16'd2; reload_i = 16'd5; run_i = 1'b1; addr_i = 8'h24;
        repeat (20) cyc("R2");
        // R3: wrap sets flag
        repeat (10) cyc("R3");
        addr_i = 8'h10; wr(8'h10, 32'h0); cyc("R7"); idle();
        // R4: block on, wraps do not set flag
        upd_block_i = 1'b1; addr_i = 8'h24;
        repeat (40) cyc("R4");
        wr(8'h14, 32'h1); cyc("R4"); idle(); cyc("R4");
        upd_block_i = 1'b0;
        // R5: forced update mid-prescale
        psc_lim_i = 16'd3; repeat (6) cyc("R5");
        wr(8'h14, 32'h1); cyc("R5"); idle(); addr_i = 8'h24; cyc("R5"); cyc("R5");
        // R6: quiet suppresses forced set
        addr_i = 8'h10; wr(8'h10, 32'h0); cyc("R6"); idle();
        run_i = 1'b0; sw_quiet_i = 1'b1; wr(8'h14, 32'h1); cyc("R6"); idle(); cyc("R6");
        sw_quiet_i = 1'b0; wr(8'h14, 32'h1); cyc("R6"); idle(); cyc("R6");
        // R7: write 1 no effect, clear, collision set wins
        wr(8'h10, 32'h1); cyc("R7"); idle(); cyc("R7");
        psc_lim_i = '0; reload_i = '0; run_i = 1'b1;
        wr(8'h10, 32'h0); cyc("R7"); idle(); cyc("R7");
        // R8: load counter, also over an advance
        run_i = 1'b0; reload_i = 16'd100;
        wr(8'h24, 32'hFFFF_0042); addr_i = 8'h24; cyc("R8"); idle(); cyc("R8");
        run_i = 1'b1; reload_i = 16'h0042; wr(8'h10, 32'h0); cyc("R8");
        wr(8'h24, 32'h0000_0007); cyc("R8"); idle(); addr_i = 8'h24; cyc("R8");
        // R9: unmapped and event word
        addr_i = 8'h00; cyc("R9"); addr_i = 8'h14; cyc("R9");
        // R10: interrupt gate
        irq_en_i = 1'b1; addr_i = 8'h10; cyc("R10"); irq_en_i = 1'b0; cyc("R10");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] pick;
            run_i       = ($urandom % 8) != 0;
            upd_block_i = ($urandom % 4) == 0;
            sw_quiet_i  = ($urandom % 2) == 0;
            irq_en_i    = ($urandom % 2) == 0;
            if ($urandom % 50 == 0) psc_lim_i = 16'($urandom % 4);
            if ($urandom % 50 == 0) reload_i  = 16'($urandom % 8);
            pick = 3'($urandom % 4);
            case (pick)
                3'd0: addr_i = 8'h10;
                3'd1: addr_i = 8'h14;
                3'd2: addr_i = 8'h24;
                default: addr_i = 8'h00;
            endcase
            wr_i    = ($urandom % 6) == 0;
            wdata_i = $urandom;
            if (addr_i == 8'h24) wdata_i[15:0] = 16'($urandom % 10);
            cyc("");
        end
        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule